// File: doc/BRIEF.md
# Adaptive Equalizer Tuning Controller

This controller picks the compensation setting of a receive cable equalizer. It holds one of twelve level codes and drives it to the analog equalizer. It reads eye-width numbers that an external monitor produces, one number per measurement with a valid strobe. The analog equalizer, the test-pattern source and the eye measurement circuit are not part of this block.

A retune is an adaptation sweep. The controller tries every level in ascending order. At each level it lets the equalizer settle for a fixed number of cycles, then keeps the next eye-width sample. At the end it applies the level that produced the widest eye.

A sweep can be started in three ways:
- a manual request;
- a free-running timer with a programmable interval;
- optionally, an eye-width sample that falls below a programmable threshold.

A below-threshold sample always raises a sticky error flag. A configuration input decides whether that sample also starts a sweep. While a sweep runs, a busy flag is high, new triggers are ignored and the threshold check is masked.

Top module: `eq_tune_ctrl`

## Requirements
- R1: The level output is a code from 0 to 11, one code for each of the twelve settings. After reset the level is 0, busy is 0, the error flag is 0, and no sweep starts until a trigger arrives.
- R2: Busy goes high, and the level output becomes 0, on the clock edge after a trigger is accepted. While busy is high, each level is held for SETTLE cycles. The first sample with ew_valid high after that is captured, and the next edge advances to the next higher level, up to 11.
- R3: On the edge that captures the sample at level 11, busy falls and the level output takes the level with the largest captured eye width. If several levels tie for the largest width, the lowest of them wins.
- R4: When the controller is idle, manual_req starts a sweep, so busy is 1 on the following cycle.
- R5: With periodic_en high and period P nonzero, a sweep starts once P consecutive idle cycles have passed since reset, since the last sweep ended, or since the timer was enabled. P equal to 0 disables the timer.
- R6: When the controller is idle, an ew_valid sample with ew_data below ew_thresh sets eye_err on the next edge.
- R7: When auto_retune is 1, the same idle below-threshold sample also starts a sweep. When auto_retune is 0, it starts none.
- R8: While busy is high, manual, timer and low-eye triggers have no effect on the sweep, and below-threshold samples do not set eye_err.
- R9: eye_err stays set until one of two events clears it on the next edge. The first is an err_clr pulse, as long as no new low sample arrives in the same cycle. The second is a sweep whose chosen eye width is at or above ew_thresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ew_data | input | EW_W | Eye-width measurement |
| ew_valid | input | 1 | ew_data holds a new sample |
| ew_thresh | input | EW_W | Minimum acceptable eye width |
| manual_req | input | 1 | Manual sweep request |
| auto_retune | input | 1 | 1: a low eye width also starts a sweep |
| periodic_en | input | 1 | Enables the periodic timer |
| period | input | PER_W | Idle cycles between periodic sweeps (0 = off) |
| err_clr | input | 1 | Write-one-to-clear for eye_err |
| eq_level | output | 4 | Equalizer level code 0..11 |
| busy | output | 1 | Sweep in progress |
| eye_err | output | 1 | Sticky low-eye flag |

## Verification
Every clock cycle, a behavioural model in the bench is compared with all three outputs. Several eye-width profiles are used, and each one separates a different fault:
- A single peak at level 7 exposes wrong best-level selection and wrong stepping order.
- Two equal maxima at levels 3 and 9 expose a tie broken toward the higher level.
- A flat low profile exposes an error flag that is wrongly cleared by a sweep that never reached the threshold.

Sparse valid strobes check that the controller waits for a sample after the settle time. Low samples injected while idle, and a request held high through a whole sweep, separate the masking of triggers during a sweep from the error and auto-retune behaviour. A run with the timer enabled and a run with period 0 separate the R5 timer from the manual path.

// File: rtl/eq_tune_ctrl.sv
module eq_tune_ctrl #(
  parameter int LEVELS = 12,
  parameter int EW_W   = 8,
  parameter int PER_W  = 16,
  parameter int SETTLE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EW_W-1:0]  ew_data,
  input  logic             ew_valid,
  input  logic [EW_W-1:0]  ew_thresh,
  input  logic             manual_req,
  input  logic             auto_retune,
  input  logic             periodic_en,
  input  logic [PER_W-1:0] period,
  input  logic             err_clr,
  output logic [3:0]       eq_level,
  output logic             busy,
  output logic             eye_err
);
  localparam int LW = 4;
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [LW-1:0] LAST = LW'(LEVELS - 1);

  logic [LW-1:0]    lvl, best;
  logic [EW_W-1:0]  best_ew;
  logic [CW-1:0]    cnt;
  logic [PER_W-1:0] tmr;
  logic             busy_q, err_q;

  wire low     = ew_valid && (ew_data < ew_thresh) && !busy_q;
  wire per_hit = periodic_en && (period != '0) && !busy_q && (tmr == period - 1'b1);
  wire start   = !busy_q && (manual_req || per_hit || (auto_retune && low));
  wire settled = (cnt == CW'(SETTLE));
  wire take    = busy_q && settled && ew_valid;
  wire better  = (lvl == '0) || (ew_data > best_ew);
  wire last    = (lvl == LAST);
  wire [LW-1:0]   pick    = better ? lvl : best;
  wire [EW_W-1:0] pick_ew = better ? ew_data : best_ew;

  assign eq_level = lvl;
  assign busy     = busy_q;
  assign eye_err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= '0; best <= '0; best_ew <= '0; cnt <= '0; busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1; lvl <= '0; cnt <= '0;
    end else if (busy_q) begin
      if (!settled) cnt <= cnt + 1'b1;
      else if (ew_valid) begin
        best <= pick; best_ew <= pick_ew; cnt <= '0;
        if (last) begin
          lvl <= pick; busy_q <= 1'b0;
        end else lvl <= lvl + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !periodic_en || period == '0 || busy_q || start) tmr <= '0;
    else tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (low) err_q <= 1'b1;
    else if (err_clr || (take && last && pick_ew >= ew_thresh)) err_q <= 1'b0;
  end

  assert_level_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eq_level < LW'(LEVELS));
  assert_sweep_from_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> eq_level == '0);
  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (eq_level == $past(eq_level) || eq_level == $past(eq_level) + 1'b1));
  assert_manual_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && manual_req) |=> busy);
  assert_low_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ew_valid && ew_data < ew_thresh) |=> eye_err);
  assert_auto_retune_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && auto_retune && ew_valid && ew_data < ew_thresh) |=> busy);
  assert_masked_in_sweep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(eye_err)) |-> !eye_err);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(!busy && ew_valid && ew_data < ew_thresh)) |=> !eye_err);
endmodule

// File: tb/eq_tune_ctrl_tb.sv
module eq_tune_ctrl_tb;
  localparam int SETTLE = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] ew_data = '0, ew_thresh = 8'd40;
  logic ew_valid = 1'b0, manual_req = 1'b0, auto_retune = 1'b0, periodic_en = 1'b0, err_clr = 1'b0;
  logic [15:0] period = '0;
  logic [3:0] eq_level;
  logic busy, eye_err;

  int checks = 0, fails = 0, cyc_n = 0, vld_every = 1;
  int prof[12];
  bit idle_vld = 0; int idle_data = 0;
  string tag = "R1";
  int m_lvl, m_best, m_bew, m_cnt, m_tmr; bit m_busy, m_err;

  always #2.5 clk = ~clk;

  eq_tune_ctrl u_dut (.clk, .rst_n, .ew_data, .ew_valid, .ew_thresh, .manual_req,
    .auto_retune, .periodic_en, .period, .err_clr, .eq_level, .busy, .eye_err);

  task automatic check(bit ok, string t, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual=%0d expected=%0d", t, act, exp); end
  endtask

  task automatic model_step();
    bit low, hit, st;
    if (!rst_n) begin
      m_lvl = 0; m_best = 0; m_bew = 0; m_cnt = 0; m_tmr = 0; m_busy = 0; m_err = 0; return;
    end
    low = ew_valid && ew_data < ew_thresh && !m_busy;
    hit = periodic_en && period != 0 && !m_busy && m_tmr == int'(period) - 1;
    st  = !m_busy && (manual_req || hit || (auto_retune && low));
    if (!periodic_en || period == 0 || m_busy || st) m_tmr = 0; else m_tmr++;
    if (low) m_err = 1;
    else if (err_clr) m_err = 0;
    if (st) begin m_busy = 1; m_lvl = 0; m_cnt = 0; end
    else if (m_busy) begin
      if (m_cnt < SETTLE) m_cnt++;
      else if (ew_valid) begin
        if (m_lvl == 0 || ew_data > m_bew) begin m_best = m_lvl; m_bew = ew_data; end
        m_cnt = 0;
        if (m_lvl == 11) begin
          m_lvl = m_best; m_busy = 0;
          if (!low && m_bew >= ew_thresh) m_err = 0;
        end else m_lvl++;
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk); model_step(); cyc_n++;
    @(negedge clk);
    check(eq_level == m_lvl && busy == m_busy && eye_err == m_err, {tag, " outputs"},
          {eq_level, busy, eye_err}, {m_lvl[3:0], m_busy, m_err});
    ew_valid = busy ? (cyc_n % vld_every == 0) : idle_vld;
    ew_data  = busy ? prof[eq_level] : idle_data;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) cyc();
  endtask

  function automatic int argmax();
    int b = 0;
    for (int i = 1; i < 12; i++) if (prof[i] > prof[b]) b = i;
    return b;
  endfunction

  task automatic pulse_manual();
    manual_req = 1; cyc(); manual_req = 0;
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc_n, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 5; i++) cyc();
    rst_n = 1;
    for (int i = 0; i < 20; i++) cyc();
    tag = "R1";
    check(eq_level == 0 && !busy && !eye_err, "R1 reset state", {eq_level, busy, eye_err}, 0);

    // R2 R3 R4: single peak at level 7
    for (int i = 0; i < 12; i++) prof[i] = 100 - 10 * ((i > 7) ? i - 7 : 7 - i);
    tag = "R4"; pulse_manual();
    check(busy, "R4 manual starts sweep", busy, 1);
    tag = "R2"; wait_idle();
    check(eq_level == argmax(), "R3 peak level", eq_level, argmax());

    // R3 tie, sparse valid; R8 request held through sweep
    for (int i = 0; i < 12; i++) prof[i] = 20;
    prof[3] = 90; prof[9] = 90; vld_every = 3;
    tag = "R8"; manual_req = 1; cyc();
    wait_idle(); manual_req = 0;
    check(eq_level == 3, "R3 tie picks lowest", eq_level, 3);
    for (int i = 0; i < 5; i++) cyc();
    check(!busy, "R8 held request no restart", busy, 0);

    // R6 low eye idle, auto off; R9 sticky and clear
    vld_every = 1; tag = "R6";
    idle_vld = 1; idle_data = 20; cyc(); idle_vld = 0; cyc();
    check(eye_err && !busy, "R6 low eye sets error", {eye_err, busy}, 2);
    tag = "R9";
    for (int i = 0; i < 6; i++) cyc();
    check(eye_err, "R9 error sticky", eye_err, 1);
    err_clr = 1; cyc(); err_clr = 0; cyc();
    check(!eye_err, "R9 clear", eye_err, 0);

    // R7 auto retune, good sweep clears error
    for (int i = 0; i < 12; i++) prof[i] = 100 - 10 * ((i > 7) ? i - 7 : 7 - i);
    tag = "R7"; auto_retune = 1;
    idle_vld = 1; idle_data = 5; cyc(); idle_vld = 0; cyc();
    check(busy && eye_err, "R7 low eye starts sweep", {busy, eye_err}, 3);
    wait_idle(); cyc(); auto_retune = 0;
    check(!eye_err && eq_level == 7, "R9 good sweep clears error", {eye_err, eq_level}, 7);

    // R8 low samples inside sweep ignored; R9 bad sweep keeps error
    for (int i = 0; i < 12; i++) prof[i] = 10;
    tag = "R8"; pulse_manual(); wait_idle(); cyc();
    check(!eye_err && eq_level == 0, "R8 low in sweep no error", {eye_err, eq_level}, 0);
    tag = "R9"; idle_vld = 1; idle_data = 1; cyc(); idle_vld = 0;
    pulse_manual(); wait_idle(); cyc();
    check(eye_err, "R9 low sweep keeps error", eye_err, 1);
    err_clr = 1; cyc(); err_clr = 0; cyc();

    // R5 periodic timer
    for (int i = 0; i < 12; i++) prof[i] = 100 - 10 * ((i > 7) ? i - 7 : 7 - i);
    tag = "R5"; period = 16'd100; periodic_en = 1; n = 0;
    for (int i = 0; i < 600; i++) begin
      bit pb = busy; cyc(); if (busy && !pb) n++;
    end
    check(n >= 3, "R5 periodic sweeps", n, 3);
    wait_idle();
    period = 16'd0; n = 0;
    for (int i = 0; i < 400; i++) begin
      bit pb = busy; cyc(); if (busy && !pb) n++;
    end
    check(n == 0, "R5 period zero disables", n, 0);
    periodic_en = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule